// File: doc/BRIEF.md
# SDRAM Open-Page Bank Tracker

This block sits between a memory request port and an SDRAM command sequencer and decides, for every access, which command sequence is needed under an open-page policy. Each of the four banks has one page register and one open flag. The page register holds the low row bits of the row that is currently activated in that bank. An incoming address is split into bank, page and column fields. The page field is compared with the bank's stored page. A match on an open bank issues the read or write command alone. Any other case issues a precharge to the bank, an activate of the new row and then the read or write command.

Once a page has been activated it stays open until a later access to the same bank misses. The position of the bank field follows a configured array size. A two-bank mode makes banks 2 and 3 illegal: a request to either of them is rejected with an error pulse and produces no command. A close-all input marks every bank closed, for example after a precharge-all or a refresh issued elsewhere.

Top module: `sdram_page_tracker`

## Requirements
- R1: With T = ADDR_W - size_sel (24 - size_sel at defaults), the bank is address bits [T-1:T-2], the page is bits [T-3:COL_W] (COL_W = 8), zero-extended to PAGE_W = 14, and the column is bits [COL_W-1:0]. Bits at or above T are ignored.
- R2: After reset, req_ready is 1, cmd_valid is 0, hit_o, miss_o and err_o are 0, and every bank is closed.
- R3: A miss issues, in this order, PRE (code 0) to the bank, then ACT (code 1) with cmd_row equal to the new page, then RD (code 2) or WR (code 3) with cmd_col equal to the column.
- R4: A hit (the bank is open and its page matches) issues only RD or WR, with no PRE and no ACT.
- R5: On a miss, the bank's page register takes the new page in the cycle in which RD/WR is accepted. A page stays open across accesses to other banks.
- R6: An access to an open bank with a different page is a miss, and that page then replaces the stored one.
- R7: An access to a closed bank (closed after reset or after close_all) is a miss.
- R8: When two_bank is 1, a request to bank 2 or 3 is accepted, raises err_o for one cycle, issues no command, and changes no bank state.
- R9: req_ready is 1 only when the block is idle. A command is held stable while cmd_valid is 1 and cmd_ready is 0. A command is accepted when cmd_valid and cmd_ready are both 1 on a clock edge.
- R10: Exactly one of hit_o or miss_o pulses for one cycle after the final command of each legal request is accepted. That same cycle is the first cycle in which req_ready is 1 again.
- R11: A one-cycle close_all while idle closes all banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| size_sel | input | 2 | Array size select; moves the bank field down by size_sel bits |
| two_bank | input | 1 | 1 when the array has two banks (banks 2 and 3 are illegal) |
| close_all | input | 1 | Marks every bank closed |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_addr | input | ADDR_W | Request address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Sequencer accepts the command |
| cmd_code | output | 2 | 0 PRE, 1 ACT, 2 RD, 3 WR |
| cmd_bank | output | 2 | Target bank |
| cmd_row | output | PAGE_W | Page (row bits) used by ACT |
| cmd_col | output | COL_W | Column used by RD/WR |
| hit_o | output | 1 | One-cycle pulse: the request completed as a page hit |
| miss_o | output | 1 | One-cycle pulse: the request completed as a page miss |
| err_o | output | 1 | One-cycle pulse: an illegal bank was requested |

## Verification
The assertions rely on the sequencer never withdrawing a command on its own. They also rely on size_sel, two_bank and close_all changing only while the block is idle, so that the PRE, ACT, RD/WR ordering and the page update run undisturbed. The bench respects these limits: it changes the configuration and pulses close_all only between requests, when req_ready is 1. It drives cmd_ready with random stalls of zero to two cycles, and it draws rows from a small pool so that hits, same-bank misses and closed-bank misses all occur often.

// File: rtl/sdpt_pkg.sv
package sdpt_pkg;

    localparam int DEF_ADDR_W = 24;
    localparam int DEF_COL_W  = 8;
    localparam int BANK_W     = 2;
    localparam int NUM_BANKS  = 4;

    typedef enum logic [1:0] {
        CMD_PRE = 2'd0,
        CMD_ACT = 2'd1,
        CMD_RD  = 2'd2,
        CMD_WR  = 2'd3
    } sdpt_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRE,
        ST_ACT,
        ST_RW
    } sdpt_state_e;

    // RD or WR depending on direction
    function automatic sdpt_cmd_e rw_code(input logic is_write);
        return is_write ? CMD_WR : CMD_RD;
    endfunction

    // a bank is illegal in two-bank mode when its upper bit is set
    function automatic logic bank_legal(input logic two_bank, input logic [BANK_W-1:0] bank);
        return !(two_bank && bank[BANK_W-1]);
    endfunction

endpackage

// File: rtl/sdpt_addr_split.sv
module sdpt_addr_split #(
    parameter int ADDR_W = 24,
    parameter int COL_W  = 8,
    parameter int PAGE_W = 14
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size_sel,
    output logic [1:0]        bank,
    output logic [PAGE_W-1:0] page,
    output logic [COL_W-1:0]  col
);

    always_comb begin
        int top_i;
        top_i = ADDR_W - int'(size_sel);
        bank  = 2'(addr >> (top_i - 2));
        for (int i = 0; i < PAGE_W; i++) begin
            page[i] = (i < top_i - 2 - COL_W) ? addr[COL_W + i] : 1'b0;
        end
        col = addr[COL_W-1:0];
    end

endmodule

// File: rtl/sdpt_page_table.sv
module sdpt_page_table #(
    parameter int NUM_BANKS = 4,
    parameter int PAGE_W    = 14
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clear_all,
    input  logic                         upd_en,
    input  logic [$clog2(NUM_BANKS)-1:0] upd_bank,
    input  logic [PAGE_W-1:0]            upd_page,
    input  logic [$clog2(NUM_BANKS)-1:0] look_bank,
    input  logic [PAGE_W-1:0]            look_page,
    output logic                         look_hit
);

    logic [NUM_BANKS-1:0] open_q;
    logic [PAGE_W-1:0]    page_q [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                open_q[b] <= 1'b0;
                page_q[b] <= '0;
            end else if (clear_all) begin
                open_q[b] <= 1'b0;
            end else if (upd_en && (upd_bank == b)) begin
                open_q[b] <= 1'b1;
                page_q[b] <= upd_page;
            end
        end
    end

    assign look_hit = open_q[look_bank] && (page_q[look_bank] == look_page);

endmodule

// File: rtl/sdpt_cmd_seq.sv
module sdpt_cmd_seq
    import sdpt_pkg::*;
#(
    parameter int PAGE_W = 14,
    parameter int COL_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              in_legal,
    input  logic              in_hit,
    input  logic [1:0]        in_bank,
    input  logic [PAGE_W-1:0] in_page,
    input  logic [COL_W-1:0]  in_col,
    input  logic              in_write,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output sdpt_cmd_e         cmd_code,
    output logic [1:0]        cmd_bank,
    output logic [PAGE_W-1:0] cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic              upd_en,
    output logic              hit_o,
    output logic              miss_o,
    output logic              err_o
);

    sdpt_state_e       state_q;
    logic [1:0]        bank_q;
    logic [PAGE_W-1:0] page_q;
    logic [COL_W-1:0]  col_q;
    logic              wr_q;
    logic              hit_q;
    logic              accept;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            bank_q  <= '0;
            page_q  <= '0;
            col_q   <= '0;
            wr_q    <= 1'b0;
            hit_q   <= 1'b0;
            hit_o   <= 1'b0;
            miss_o  <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            hit_o  <= 1'b0;
            miss_o <= 1'b0;
            err_o  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        bank_q <= in_bank;
                        page_q <= in_page;
                        col_q  <= in_col;
                        wr_q   <= in_write;
                        hit_q  <= in_hit;
                        if (!in_legal) begin
                            err_o <= 1'b1;
                        end else if (in_hit) begin
                            state_q <= ST_RW;
                        end else begin
                            state_q <= ST_PRE;
                        end
                    end
                end
                ST_PRE: if (cmd_ready) state_q <= ST_ACT;
                ST_ACT: if (cmd_ready) state_q <= ST_RW;
                ST_RW: begin
                    if (cmd_ready) begin
                        state_q <= ST_IDLE;
                        hit_o   <= hit_q;
                        miss_o  <= !hit_q;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd_valid = (state_q != ST_IDLE);
        case (state_q)
            ST_PRE:  cmd_code = CMD_PRE;
            ST_ACT:  cmd_code = CMD_ACT;
            default: cmd_code = rw_code(wr_q);
        endcase
        cmd_bank = bank_q;
        cmd_row  = page_q;
        cmd_col  = col_q;
        upd_en   = (state_q == ST_RW) && cmd_ready && !hit_q;
    end

endmodule

// File: rtl/sdram_page_tracker.sv
module sdram_page_tracker
    import sdpt_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int COL_W  = DEF_COL_W,
    localparam int PAGE_W = ADDR_W - BANK_W - COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        size_sel,
    input  logic              two_bank,
    input  logic              close_all,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [1:0]        cmd_code,
    output logic [1:0]        cmd_bank,
    output logic [PAGE_W-1:0] cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic              hit_o,
    output logic              miss_o,
    output logic              err_o
);

    logic [1:0]        sp_bank;
    logic [PAGE_W-1:0] sp_page;
    logic [COL_W-1:0]  sp_col;
    logic              look_hit;
    logic              upd_en;
    sdpt_cmd_e         code_e;

    sdpt_addr_split #(.ADDR_W(ADDR_W), .COL_W(COL_W), .PAGE_W(PAGE_W)) u_split (
        .addr     (req_addr),
        .size_sel (size_sel),
        .bank     (sp_bank),
        .page     (sp_page),
        .col      (sp_col)
    );

    sdpt_page_table #(.NUM_BANKS(NUM_BANKS), .PAGE_W(PAGE_W)) u_table (
        .clk       (clk),
        .rst       (rst),
        .clear_all (close_all),
        .upd_en    (upd_en),
        .upd_bank  (cmd_bank),
        .upd_page  (cmd_row),
        .look_bank (sp_bank),
        .look_page (sp_page),
        .look_hit  (look_hit)
    );

    sdpt_cmd_seq #(.PAGE_W(PAGE_W), .COL_W(COL_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .in_legal  (bank_legal(two_bank, sp_bank)),
        .in_hit    (look_hit),
        .in_bank   (sp_bank),
        .in_page   (sp_page),
        .in_col    (sp_col),
        .in_write  (req_write),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_code  (code_e),
        .cmd_bank  (cmd_bank),
        .cmd_row   (cmd_row),
        .cmd_col   (cmd_col),
        .upd_en    (upd_en),
        .hit_o     (hit_o),
        .miss_o    (miss_o),
        .err_o     (err_o)
    );

    assign cmd_code = code_e;

endmodule

// File: rtl/sdpt_checker.sv
module sdpt_checker (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic [1:0] cmd_code,
    input logic [1:0] cmd_bank,
    input logic       hit_o,
    input logic       miss_o,
    input logic       err_o
);

    assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_code) && $stable(cmd_bank));

    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready || err_o);

    assert_pre_then_act_R3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready && cmd_code == 2'd0 |=> cmd_valid && cmd_code == 2'd1 && $stable(cmd_bank));

    assert_act_then_rw_R3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready && cmd_code == 2'd1 |=> cmd_valid && cmd_code[1] && $stable(cmd_bank));

    assert_rw_completes_R10: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready && cmd_code[1] |=> (hit_o ^ miss_o) && req_ready && !cmd_valid);

    assert_err_no_cmd_R8: assert property (@(posedge clk) disable iff (rst)
        err_o |-> !cmd_valid && !hit_o && !miss_o);

    assert_pulse_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hit_o, miss_o, err_o}));

endmodule

bind sdram_page_tracker sdpt_checker u_sdpt_checker (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_code  (cmd_code),
    .cmd_bank  (cmd_bank),
    .hit_o     (hit_o),
    .miss_o    (miss_o),
    .err_o     (err_o)
);

// File: tb/test_sdram_page_tracker.sv
module test_sdram_page_tracker;

    localparam int ADDR_W = 24;
    localparam int COL_W  = 8;
    localparam int PAGE_W = ADDR_W - 2 - COL_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        size_sel = 2'd0;
    logic              two_bank = 1'b0;
    logic              close_all = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_write = 1'b0;
    logic              cmd_valid;
    logic              cmd_ready = 1'b0;
    logic [1:0]        cmd_code;
    logic [1:0]        cmd_bank;
    logic [PAGE_W-1:0] cmd_row;
    logic [COL_W-1:0]  cmd_col;
    logic              hit_o, miss_o, err_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    bit exp_open [4];
    int exp_page [4];

    always #2 clk = ~clk;

    sdram_page_tracker #(.ADDR_W(ADDR_W), .COL_W(COL_W)) i_sdram_page_tracker (
        .clk(clk), .rst(rst), .size_sel(size_sel), .two_bank(two_bank),
        .close_all(close_all), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
        .cmd_row(cmd_row), .cmd_col(cmd_col), .hit_o(hit_o), .miss_o(miss_o),
        .err_o(err_o)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int row_bits();
        return ADDR_W - int'(size_sel) - 2 - COL_W;
    endfunction

    function automatic int mask_page(input int page);
        return page & ((1 << row_bits()) - 1);
    endfunction

    function automatic logic [ADDR_W-1:0] mk_addr(input int bank, input int page, input int col, input int junk);
        int top;
        logic [31:0] a;
        top = ADDR_W - int'(size_sel);
        a = (32'(junk) << top) | (32'(bank) << (top - 2)) | (32'(mask_page(page)) << COL_W) | 32'(col & 8'hFF);
        return a[ADDR_W-1:0];
    endfunction

    // presents one command check with random stall
    task automatic take_cmd(input int code, input int bank, input int row, input int col, input string req);
        int stall;
        stall = $urandom % 3;
        for (int s = 0; s <= stall; s++) begin
            chk(cmd_valid == 1'b1, req, "cmd_valid", int'(cmd_valid), 1);
            chk(int'(cmd_code) == code, req, "cmd_code", int'(cmd_code), code);
            chk(int'(cmd_bank) == bank, req, "cmd_bank", int'(cmd_bank), bank);
            if (code == 1) chk(int'(cmd_row) == row, req, "cmd_row", int'(cmd_row), row);
            if (code >= 2) chk(int'(cmd_col) == col, req, "cmd_col", int'(cmd_col), col);
            if (s == stall) cmd_ready = 1'b1;
            @(negedge clk);
            cmd_ready = 1'b0;
        end
    endtask

    task automatic run_req(input int bank, input int page, input int col, input bit wr, input int junk, input string req);
        int  pg;
        bit  illegal, exp_hit;
        pg      = mask_page(page);
        illegal = two_bank && (bank >= 2);
        exp_hit = exp_open[bank] && (exp_page[bank] == pg);
        chk(req_ready == 1'b1, "R9", "req_ready idle", int'(req_ready), 1);
        req_valid = 1'b1;
        req_addr  = mk_addr(bank, page, col, junk);
        req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        if (illegal) begin
            chk(err_o == 1'b1, "R8", "err_o", int'(err_o), 1);
            chk(cmd_valid == 1'b0, "R8", "cmd_valid on error", int'(cmd_valid), 0);
            chk(req_ready == 1'b1, "R8", "ready after error", int'(req_ready), 1);
            return;
        end
        chk(req_ready == 1'b0, "R9", "req_ready busy", int'(req_ready), 0);
        if (!exp_hit) begin
            take_cmd(0, bank, pg, col, "R3");
            take_cmd(1, bank, pg, col, "R3");
        end
        take_cmd(wr ? 3 : 2, bank, pg, col, exp_hit ? "R4" : "R3");
        chk(hit_o == exp_hit, exp_hit ? "R4" : "R6", "hit_o", int'(hit_o), int'(exp_hit));
        chk(miss_o == !exp_hit, "R10", "miss_o", int'(miss_o), int'(!exp_hit));
        chk(req_ready == 1'b1, "R10", "ready with pulse", int'(req_ready), 1);
        @(negedge clk);
        chk(!hit_o && !miss_o, "R10", "pulse width", int'({hit_o, miss_o}), 0);
        exp_open[bank] = 1'b1;
        exp_page[bank] = pg;
    endtask

    task automatic pulse_close();
        close_all = 1'b1;
        @(negedge clk);
        close_all = 1'b0;
        for (int b = 0; b < 4; b++) exp_open[b] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int b = 0; b < 4; b++) begin exp_open[b] = 0; exp_page[b] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2 reset state
        chk(req_ready == 1'b1, "R2", "req_ready", int'(req_ready), 1);
        chk(cmd_valid == 1'b0, "R2", "cmd_valid", int'(cmd_valid), 0);
        chk({hit_o, miss_o, err_o} == 3'b0, "R2", "pulses", int'({hit_o, miss_o, err_o}), 0);

        // R7 closed bank misses, R5 then hits
        run_req(1, 5, 9, 0, 0, "R7");
        run_req(1, 5, 10, 1, 0, "R5");
        // R5 other bank does not disturb open page
        run_req(2, 7, 1, 0, 0, "R5");
        run_req(1, 5, 11, 0, 0, "R5");
        // R6 new row in open bank
        run_req(1, 6, 0, 1, 0, "R6");
        run_req(1, 6, 255, 0, 0, "R6");
        // R11 close all then R7 miss
        pulse_close();
        run_req(1, 6, 3, 0, 0, "R11");
        // R8 two-bank mode: illegal then legal state untouched
        two_bank = 1'b1;
        run_req(3, 6, 3, 0, 0, "R8");
        run_req(2, 1, 3, 1, 0, "R8");
        run_req(1, 6, 4, 0, 0, "R8");
        two_bank = 1'b0;
        // R1 size select with junk above the field
        size_sel = 2'd3;
        pulse_close();
        run_req(3, 16'h7FF, 8'hA5, 0, 5, "R1");
        run_req(3, 16'h7FF, 8'h5A, 1, 2, "R1");
        run_req(0, 0, 0, 0, 7, "R1");

        // random mix
        for (int n = 0; n < 400; n++) begin
            int r;
            if ($urandom % 40 == 0) begin
                size_sel = 2'($urandom % 4);
                pulse_close();
            end
            if ($urandom % 25 == 0) pulse_close();
            two_bank = ($urandom % 4 == 0);
            r = $urandom % 4;
            run_req($urandom % 4, (r == 3) ? 32'h3FFF : r, $urandom % 256,
                    $urandom % 2, $urandom % 8, "R5");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule